// File: doc/BRIEF.md
# Frame-Buffered Sobel Edge Detector

This block turns one small colour frame into a binary edge map. After a start pulse it fetches every 24-bit RGB pixel of the frame through a synchronous read port with one cycle of latency. It keeps the whole frame inside and converts each pixel to an 8-bit luma value with an integer weighting. It then applies the two 3x3 Sobel kernels to every pixel that has a full neighbourhood and compares |Gx| + |Gy| against a threshold parameter. Finally it streams one edge bit per pixel, in row-major order, to a write port.

The work runs as separate whole-frame phases under one controller: idle, load, gray, sobel, dump and done, in that order, then back to idle. The frame size and the threshold are parameters. All counter and address widths are derived from the frame size. A one-cycle done pulse closes each run. A start pulse that arrives while a run is in progress is ignored.

Top module: `sobel_frame_edge`

## Requirements
- R1: While reset is held and afterwards until a start pulse, `rd_en`, `wr_en` and `done` stay low.
- R2: A start pulse that arrives while a run is in progress changes neither the number of reads, the number of writes, the output bits nor the completion cycle.
- R3: In the cycle after the edge that accepts start, `rd_en` rises. It then stays high for WIDTH*HEIGHT consecutive cycles with `rd_addr` stepping 0,1,2,...; the address of pixel (row, col) is row*WIDTH+col. Reads and writes never occur in the same cycle.
- R4: Each pixel's gray value is (77*R + 150*G + 29*B) >> 8, where R is `rd_data[23:16]`, G is `rd_data[15:8]` and B is `rd_data[7:0]`.
- R5: An interior pixel's edge bit is 1 exactly when |Gx| + |Gy| > THRESHOLD. Gx uses kernel rows (-1 0 1), (-2 0 2), (-1 0 1) and Gy uses rows (-1 -2 -1), (0 0 0), (1 2 1) over the gray neighbourhood, with the top row first. Equality gives 0.
- R6: Pixels in the first or last row or column get edge bit 0.
- R7: The dump issues exactly WIDTH*HEIGHT writes on consecutive cycles with `wr_addr` stepping 0,1,2,... and `wr_bit` carrying that pixel's edge bit.
- R8: `done` is high for exactly one cycle, in the cycle after the last write. The block then accepts a new start.
- R9: `done` is high in the cycle that begins 4*WIDTH*HEIGHT+1 rising edges after the edge that accepts start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; honoured only when idle |
| rd_en | output | 1 | Read request to the pixel memory |
| rd_addr | output | AW | Pixel address for the read |
| rd_data | input | 24 | RGB pixel, returned one cycle after the request |
| wr_en | output | 1 | Edge bit write strobe |
| wr_addr | output | AW | Pixel address for the write |
| wr_bit | output | 1 | Edge bit |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The two functions that can meet in one cycle are a new start request and an active processing phase. This matters most during the pixel fetch, while reads are still being issued, and during the dump, while writes are streaming. The bench raises a stray start pulse at chosen cycles inside the load and dump phases of otherwise normal runs. It judges the outcome at the ports: the read and write counts, the address sequences, the completion cycle and every edge bit must match a run without the stray pulse.

// File: rtl/sobel_pkg.sv
package sobel_pkg;
   typedef struct packed {
      logic [7:0] r;
      logic [7:0] g;
      logic [7:0] b;
   } rgb_t;

   typedef enum logic [2:0] {
      PH_IDLE, PH_LOAD, PH_GRAY, PH_SOBEL, PH_DUMP, PH_DONE
   } phase_e;
endpackage

// File: rtl/luma_conv.sv
module luma_conv
   import sobel_pkg::*;
(
   input  rgb_t       px,
   output logic [7:0] y
);
   logic [15:0] acc;
   always_comb begin
      acc = 16'(16'd77 * px.r) + 16'(16'd150 * px.g) + 16'(16'd29 * px.b);
      y   = acc[15:8];
   end
endmodule

// File: rtl/sobel_kernel.sv
module sobel_kernel #(
   parameter int THRESHOLD = 100,
   parameter int MW        = 12
) (
   input  logic [71:0] win,
   output logic        hit
);
   logic signed [MW-1:0] p [9];
   logic signed [MW-1:0] gx, gy, ax, ay;
   logic        [MW-1:0] mag;

   for (genvar t = 0; t < 9; t++) begin : g_tap
      assign p[t] = MW'(win[t*8 +: 8]);
   end

   always_comb begin
      gx  = (p[2] + 2*p[5] + p[8]) - (p[0] + 2*p[3] + p[6]);
      gy  = (p[6] + 2*p[7] + p[8]) - (p[0] + 2*p[1] + p[2]);
      ax  = gx[MW-1] ? -gx : gx;
      ay  = gy[MW-1] ? -gy : gy;
      mag = MW'(ax + ay);
      hit = (int'(mag) > THRESHOLD);
   end
endmodule

// File: rtl/phase_ctrl.sv
module phase_ctrl
   import sobel_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter int HEIGHT = 8,
   localparam int NPIX  = WIDTH * HEIGHT,
   localparam int AW    = $clog2(NPIX),
   localparam int CW    = $clog2(WIDTH),
   localparam int RW    = $clog2(HEIGHT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output phase_e        phase,
   output logic [AW-1:0] idx,
   output logic [RW-1:0] row,
   output logic [CW-1:0] col,
   output logic          issue,
   output logic          cap_vld,
   output logic [AW-1:0] cap_idx
);
   logic iss_done, last, cap_last;

   assign last     = (idx == AW'(NPIX - 1));
   assign cap_last = cap_vld && (cap_idx == AW'(NPIX - 1));
   assign issue    = (phase == PH_LOAD) && !iss_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         idx      <= '0;
         row      <= '0;
         col      <= '0;
         iss_done <= 1'b0;
         cap_vld  <= 1'b0;
         cap_idx  <= '0;
      end else begin
         cap_vld <= issue;
         cap_idx <= idx;
         unique case (phase)
            PH_IDLE: if (start) begin
               phase    <= PH_LOAD;
               iss_done <= 1'b0;
            end
            PH_LOAD: begin
               if (issue) begin
                  idx <= last ? '0 : idx + 1'b1;
                  if (last) iss_done <= 1'b1;
               end
               if (cap_last) phase <= PH_GRAY;
            end
            PH_GRAY, PH_SOBEL, PH_DUMP: begin
               if (last) begin
                  idx   <= '0;
                  row   <= '0;
                  col   <= '0;
                  phase <= (phase == PH_GRAY)  ? PH_SOBEL :
                           (phase == PH_SOBEL) ? PH_DUMP  : PH_DONE;
               end else begin
                  idx <= idx + 1'b1;
                  if (col == CW'(WIDTH - 1)) begin
                     col <= '0;
                     row <= row + 1'b1;
                  end else begin
                     col <= col + 1'b1;
                  end
               end
            end
            PH_DONE: phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sobel_frame_edge.sv
module sobel_frame_edge
   import sobel_pkg::*;
#(
   parameter int WIDTH     = 8,
   parameter int HEIGHT    = 8,
   parameter int THRESHOLD = 100,
   localparam int NPIX     = WIDTH * HEIGHT,
   localparam int AW       = $clog2(NPIX),
   localparam int CW       = $clog2(WIDTH),
   localparam int RW       = $clog2(HEIGHT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   input  logic [23:0]   rd_data,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic          wr_bit,
   output logic          done
);
   if (WIDTH < 3 || HEIGHT < 3) begin : g_bad_size
      $error("frame must be at least 3x3");
   end
   if (THRESHOLD < 0 || THRESHOLD > 2040) begin : g_bad_thr
      $error("threshold outside magnitude range");
   end

   phase_e        phase;
   logic [AW-1:0] idx, cap_idx;
   logic [RW-1:0] row;
   logic [CW-1:0] col;
   logic          issue, cap_vld, interior, k_hit;
   logic [7:0]    y_cur;
   logic [71:0]   win;

   rgb_t       rgb_q  [NPIX];
   logic [7:0] gray_q [NPIX];
   logic       edge_q [NPIX];

   phase_ctrl #(.WIDTH(WIDTH), .HEIGHT(HEIGHT)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .phase(phase),
      .idx(idx), .row(row), .col(col), .issue(issue),
      .cap_vld(cap_vld), .cap_idx(cap_idx)
   );

   luma_conv u_luma (.px(rgb_q[idx]), .y(y_cur));

   assign interior = (row != '0) && (row != RW'(HEIGHT - 1)) &&
                     (col != '0) && (col != CW'(WIDTH - 1));

   for (genvar dr = 0; dr < 3; dr++) begin : g_row
      for (genvar dc = 0; dc < 3; dc++) begin : g_col
         logic [AW-1:0] tap;
         assign tap = AW'(int'(idx) + (dr - 1) * WIDTH + (dc - 1));
         assign win[(dr*3+dc)*8 +: 8] = interior ? gray_q[tap] : 8'd0;
      end
   end

   sobel_kernel #(.THRESHOLD(THRESHOLD)) u_kern (.win(win), .hit(k_hit));

   always_ff @(posedge clk) begin
      if (cap_vld) rgb_q[cap_idx] <= rgb_t'(rd_data);
      if (phase == PH_GRAY)  gray_q[idx] <= y_cur;
      if (phase == PH_SOBEL) edge_q[idx] <= interior && k_hit;
   end

   assign rd_en   = issue;
   assign rd_addr = idx;
   assign wr_en   = (phase == PH_DUMP);
   assign wr_addr = idx;
   assign wr_bit  = wr_en && edge_q[idx];
   assign done    = (phase == PH_DONE);
endmodule

// File: rtl/sobel_frame_edge_chk.sv
module sobel_frame_edge_chk #(
   parameter int WIDTH  = 8,
   parameter int HEIGHT = 8,
   localparam int NPIX  = WIDTH * HEIGHT,
   localparam int AW    = $clog2(NPIX)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_en,
   input logic [AW-1:0] rd_addr,
   input logic          wr_en,
   input logic [AW-1:0] wr_addr,
   input logic          wr_bit,
   input logic          done
);
   logic on_border;
   assign on_border = (int'(wr_addr) % WIDTH == 0) || (int'(wr_addr) % WIDTH == WIDTH - 1) ||
                      (int'(wr_addr) < WIDTH) || (int'(wr_addr) >= NPIX - WIDTH);

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(wr_en) && ($past(wr_addr) == AW'(NPIX - 1))); // R8
   AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && $past(rd_en) |-> rd_addr == $past(rd_addr) + 1'b1); // R3
   AST_RD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> int'(rd_addr) < NPIX); // R3
   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && wr_en)); // R3
   AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + 1'b1); // R7
   AST_BORDER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && on_border |-> !wr_bit); // R6
endmodule

bind sobel_frame_edge sobel_frame_edge_chk #(.WIDTH(WIDTH), .HEIGHT(HEIGHT)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit), .done(done)
);

// File: tb/sim_sobel_frame_edge.sv
module sim_sobel_frame_edge;
   localparam int W = 8, H = 8, TH = 100;
   localparam int N = W * H;
   localparam int AW = $clog2(N);

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic rd_en, wr_en, wr_bit, done;
   logic [AW-1:0] rd_addr, wr_addr;
   logic [23:0] rd_data;

   logic [23:0] mem [N];
   bit          got [N];
   int n_chk = 0, n_err = 0, rd_cnt = 0, wr_cnt = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sobel_frame_edge #(.WIDTH(W), .HEIGHT(H), .THRESHOLD(TH)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit), .done(done)
   );

   always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   always @(negedge clk) if (rst_n) begin
      if (rd_en) begin
         check(int'(rd_addr) == rd_cnt, "R3 read address", int'(rd_addr), rd_cnt);
         rd_cnt++;
      end
      if (wr_en) begin
         check(int'(wr_addr) == wr_cnt, "R7 write address", int'(wr_addr), wr_cnt);
         got[wr_addr] = wr_bit;
         wr_cnt++;
      end
   end

   function automatic int luma(input logic [23:0] p);
      return (77 * p[23:16] + 150 * p[15:8] + 29 * p[7:0]) >> 8;
   endfunction

   function automatic bit ref_edge(input int r, input int c);
      int g [3][3];
      int gx, gy;
      if (r == 0 || c == 0 || r == H - 1 || c == W - 1) return 1'b0;
      for (int i = 0; i < 3; i++)
         for (int j = 0; j < 3; j++) g[i][j] = luma(mem[(r + i - 1) * W + c + j - 1]);
      gx = (g[0][2] + 2 * g[1][2] + g[2][2]) - (g[0][0] + 2 * g[1][0] + g[2][0]);
      gy = (g[2][0] + 2 * g[2][1] + g[2][2]) - (g[0][0] + 2 * g[0][1] + g[0][2]);
      return ((gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy)) > TH;
   endfunction

   task automatic run_frame(input int stray_k);
      int k = 0;
      @(negedge clk);
      rd_cnt = 0; wr_cnt = 0;
      for (int i = 0; i < N; i++) got[i] = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(rd_en == 1'b1, "R3 first read", int'(rd_en), 1);
      while (!done && k < 5000) begin
         start = (k == stray_k);
         @(negedge clk);
         k++;
      end
      start = 1'b0;
      check(k == 4 * N + 1, "R9 done cycle", k, 4 * N + 1);
      check(rd_cnt == N, "R2 read count", rd_cnt, N);
      check(wr_cnt == N, "R7 write count", wr_cnt, N);
      for (int r = 0; r < H; r++)
         for (int c = 0; c < W; c++) begin
            bit e = ref_edge(r, c);
            if (r == 0 || c == 0 || r == H - 1 || c == W - 1)
               check(got[r * W + c] == e, "R6 border bit", got[r * W + c], e);
            else
               check(got[r * W + c] == e, "R5 edge bit (R4 luma)", got[r * W + c], e);
         end
      @(negedge clk);
      check(done == 1'b0, "R8 done single", int'(done), 0);
   endtask

   task automatic step_frame(input logic [23:0] lo, input logic [23:0] hi);
      for (int i = 0; i < N; i++) mem[i] = (i % W < W / 2) ? lo : hi;
   endtask

   initial begin
      void'($urandom(32'd20251));
      repeat (3) @(negedge clk);
      check(!rd_en && !wr_en && !done, "R1 reset outputs", {rd_en, wr_en, done}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(!rd_en && !wr_en && !done, "R1 idle outputs", {rd_en, wr_en, done}, 0);

      for (int i = 0; i < N; i++) mem[i] = 24'd0;
      run_frame(-1);
      step_frame({3{8'd0}}, {3{8'd25}});   // R5 magnitude equals threshold
      run_frame(-1);
      step_frame({3{8'd0}}, {3{8'd26}});   // R5 just above threshold
      run_frame(-1);
      step_frame(24'hFF0000, 24'h0000FF);  // R4 colour weighting
      run_frame(-1);
      for (int f = 0; f < 3; f++) begin
         for (int i = 0; i < N; i++)
            mem[i] = (f == 0) ? 24'($urandom) : {8'($urandom_range(0, 31)), 8'($urandom_range(0, 31)), 8'($urandom_range(0, 31))};
         run_frame(f == 1 ? 10 : -1);      // R2 stray start during load
      end
      for (int i = 0; i < N; i++) mem[i] = 24'($urandom);
      run_frame(3 * N + 5);                // R2 stray start during dump
      run_frame(N);                        // R2 stray start on last capture
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule